// File: doc/BRIEF.md
# PPS-Latched Seconds/Ticks Timekeeper

This block keeps absolute time as a pair of counters: a whole-seconds count and a sub-second tick count. The tick count advances by one on every clock. When it reaches the last tick of a second, it returns to zero and the seconds count advances. Software sets the number of ticks in one second through a settings register, so the same block works at any sample clock rate.

Software sets a new time by writing the wanted seconds and ticks, then arming the load through a mode register. The armed load is applied either on the next clock or on the next edge of a pulse-per-second (PPS) input. A flags register picks the edge direction and which of two PPS inputs is used. Each PPS input passes through a two-flop synchronizer and an edge detector before it can commit a load. Code that stamps packets reads the two time outputs directly.

Top module: `pps_timekeeper`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both time outputs become 0, the ticks-per-second value returns to the parameter `DEFAULT_TPS`, no load is armed, and the flags select a falling edge on `pps_main`.
- R2: With no load committing, each clock adds 1 to `now_ticks`. In the cycle where `now_ticks` equals ticks-per-second minus 1, `now_ticks` becomes 0 and `now_secs` goes up by 1.
- R3: The settings index decodes as follows. Index 0 is the pending seconds and index 1 the pending ticks. Index 2 holds the flags: bit 0 set means a rising edge, bit 1 set means the `pps_aux` input. Index 3 arms a load, and its data bit 0 selects the mode. Index 4 is ticks-per-second. A write to index 5, 6 or 7 changes nothing that can be observed.
- R4: A write to index 3 with data bit 0 = 1 commits the pending time on the next clock edge. The outputs show the written seconds and ticks right after that edge.
- R5: A write to index 3 with data bit 0 = 0 arms a load that waits for a PPS edge. The input passes through two synchronizer flops, so a PPS level change that is stable before edge k commits the load at edge k+2. The outputs keep counting freely until then.
- R6: With flags bit 0 = 0, only a falling PPS edge commits. With flags bit 0 = 1, only a rising edge commits. An edge of the other direction leaves the armed load waiting.
- R7: With flags bit 1 = 0, `pps_main` is the source. With flags bit 1 = 1, `pps_aux` is the source. Activity on the input that is not selected commits nothing.
- R8: PPS edges that occur while no load is armed have no effect. A committed load disarms, so later edges do not load the time again.
- R9: A write to index 0 or index 1 after arming but before the commit replaces the pending value. The commit uses the newest value.
- R10: A load that commits in the rollover cycle wins over the rollover. The outputs take the loaded values, not 0 ticks and seconds plus 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time base clock; one tick per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Settings write strobe |
| cfg_idx | input | 3 | Settings index within the timekeeper group |
| cfg_data | input | DATA_W | Settings write data |
| pps_main | input | 1 | Primary PPS input (asynchronous) |
| pps_aux | input | 1 | Alternate PPS input (asynchronous) |
| now_secs | output | SEC_W | Current seconds count |
| now_ticks | output | TICK_W | Current tick count within the second |

## Verification
Free counting is tried with many random pairs of tick rate and start time, each followed by a random wait. The wait crosses zero, one or several second boundaries, so errors in the wrap point and in carry arithmetic show up separately. The PPS path is driven with each edge direction and each source. The wrong direction and the unselected input are each toggled while a load is armed. This tells a correct selection apart from a block that commits on any edge. Timed probes one cycle before the expected commit catch a synchronizer that is too short or too long. Further directed cases cover a second edge after the commit, an overwrite while armed, a commit that lands in the rollover cycle, and writes to unused indices.

// File: rtl/tk_pkg.sv
// Shared settings-index encoding and flag bit positions for the timekeeper.
package tk_pkg;
    typedef enum logic [2:0] {
        IDX_SECS  = 3'd0,
        IDX_TICKS = 3'd1,
        IDX_FLAGS = 3'd2,
        IDX_ARM   = 3'd3,
        IDX_RATE  = 3'd4
    } tk_idx_e;

    localparam int FLAG_RISE_BIT = 0;
    localparam int FLAG_AUX_BIT  = 1;
    localparam int ARM_IMM_BIT   = 0;
endpackage

// File: rtl/tk_settings.sv
// Settings decode and pending-load state for the timekeeper.
// Holds the pending seconds/ticks, the PPS flags, the tick rate and the armed
// flag. Assumes SEC_W and TICK_W do not exceed DATA_W. A write to the arm index
// in the same cycle as a commit leaves the load armed.
module tk_settings
    import tk_pkg::*;
#(
    parameter int SEC_W       = 32,
    parameter int TICK_W      = 32,
    parameter int DATA_W      = 32,
    parameter int DEFAULT_TPS = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit,
    output logic [SEC_W-1:0]  ld_secs,
    output logic [TICK_W-1:0] ld_ticks,
    output logic [TICK_W-1:0] rate,
    output logic              sel_rise,
    output logic              sel_aux,
    output logic              armed,
    output logic              imm_mode,
    output logic              arm_wr
);
    logic hit_secs, hit_ticks, hit_flags, hit_rate;

    // Purpose: one strobe per decoded index.
    always_comb begin
        hit_secs  = wr_en && (wr_idx == IDX_SECS);
        hit_ticks = wr_en && (wr_idx == IDX_TICKS);
        hit_flags = wr_en && (wr_idx == IDX_FLAGS);
        hit_rate  = wr_en && (wr_idx == IDX_RATE);
        arm_wr    = wr_en && (wr_idx == IDX_ARM);
    end

    // Purpose: hold the value registers that software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_secs  <= '0;
            ld_ticks <= '0;
            rate     <= TICK_W'(DEFAULT_TPS);
            sel_rise <= 1'b0;
            sel_aux  <= 1'b0;
        end else begin
            if (hit_secs)  ld_secs  <= wr_data[SEC_W-1:0];
            if (hit_ticks) ld_ticks <= wr_data[TICK_W-1:0];
            if (hit_rate)  rate     <= wr_data[TICK_W-1:0];
            if (hit_flags) begin
                sel_rise <= wr_data[FLAG_RISE_BIT];
                sel_aux  <= wr_data[FLAG_AUX_BIT];
            end
        end
    end

    // Purpose: arm on a write to the arm index and disarm on commit; arming wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            imm_mode <= 1'b0;
        end else if (arm_wr) begin
            armed    <= 1'b1;
            imm_mode <= wr_data[ARM_IMM_BIT];
        end else if (commit) begin
            armed    <= 1'b0;
        end
    end
endmodule

// File: rtl/tk_pps_edge.sv
// PPS source select, synchronizer and edge detector.
// Chooses one of two asynchronous PPS inputs, passes it through SYNC_STAGES
// flops and then flags the chosen edge direction as a one-cycle pulse. It assumes
// the PPS pulses are much longer than a clock period.
module tk_pps_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pps_a,
    input  logic pps_b,
    input  logic use_b,
    input  logic want_rise,
    output logic pps_hit
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic               raw_sel;
    logic [CHAIN_W-1:0] chain;
    logic               now_lvl, old_lvl;

    // Purpose: pick the source before synchronizing.
    always_comb raw_sel = use_b ? pps_b : pps_a;

    // Purpose: synchronizer flops plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[CHAIN_W-2:0], raw_sel};
    end

    // Purpose: compare the synchronized level with its previous value.
    always_comb begin
        now_lvl = chain[SYNC_STAGES-1];
        old_lvl = chain[SYNC_STAGES];
        pps_hit = want_rise ? (now_lvl && !old_lvl) : (!now_lvl && old_lvl);
    end
endmodule

// File: rtl/tk_counter.sv
// Seconds/ticks counter with a programmable wrap and a priority load.
// A load wins over both increment and rollover. A rate of 0 makes ticks
// wrap at the all-ones value.
module tk_counter #(
    parameter int SEC_W  = 32,
    parameter int TICK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SEC_W-1:0]  ld_secs,
    input  logic [TICK_W-1:0] ld_ticks,
    input  logic [TICK_W-1:0] rate,
    output logic [SEC_W-1:0]  secs,
    output logic [TICK_W-1:0] ticks
);
    logic last_tick;

    // Purpose: detect the final tick of the current second.
    always_comb last_tick = (ticks == rate - TICK_W'(1));

    // Purpose: load, roll over or step the time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            secs  <= '0;
            ticks <= '0;
        end else if (load) begin
            secs  <= ld_secs;
            ticks <= ld_ticks;
        end else if (last_tick) begin
            secs  <= secs + SEC_W'(1);
            ticks <= '0;
        end else begin
            ticks <= ticks + TICK_W'(1);
        end
    end
endmodule

// File: rtl/pps_timekeeper.sv
// Top of the PPS-latched timekeeper: settings decode, PPS edge path and counter.
// A load commits when armed and either in immediate mode or on the chosen
// PPS edge. Settings writes are single-cycle strobes in the clk domain.
module pps_timekeeper #(
    parameter int SEC_W       = 32,
    parameter int TICK_W      = 32,
    parameter int DATA_W      = 32,
    parameter int DEFAULT_TPS = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_idx,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic              pps_main,
    input  logic              pps_aux,
    output logic [SEC_W-1:0]  now_secs,
    output logic [TICK_W-1:0] now_ticks
);
    logic [SEC_W-1:0]  ld_secs;
    logic [TICK_W-1:0] ld_ticks;
    logic [TICK_W-1:0] rate;
    logic sel_rise, sel_aux, armed, imm_mode, arm_wr, pps_hit, commit;

    tk_settings #(
        .SEC_W(SEC_W), .TICK_W(TICK_W), .DATA_W(DATA_W), .DEFAULT_TPS(DEFAULT_TPS)
    ) u_set (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_idx),
        .wr_data(cfg_data), .commit(commit), .ld_secs(ld_secs),
        .ld_ticks(ld_ticks), .rate(rate), .sel_rise(sel_rise),
        .sel_aux(sel_aux), .armed(armed), .imm_mode(imm_mode), .arm_wr(arm_wr)
    );

    tk_pps_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pps (
        .clk(clk), .rst_n(rst_n), .pps_a(pps_main), .pps_b(pps_aux),
        .use_b(sel_aux), .want_rise(sel_rise), .pps_hit(pps_hit)
    );

    // Purpose: decide when the pending time is applied.
    always_comb commit = armed && (imm_mode || pps_hit);

    tk_counter #(.SEC_W(SEC_W), .TICK_W(TICK_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(commit), .ld_secs(ld_secs),
        .ld_ticks(ld_ticks), .rate(rate), .secs(now_secs), .ticks(now_ticks)
    );
endmodule

// File: rtl/tk_checker.sv
// Temporal checks for the timekeeper, bound to the top module.
module tk_checker #(
    parameter int SEC_W  = 32,
    parameter int TICK_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              commit,
    input logic              armed,
    input logic              arm_wr,
    input logic [TICK_W-1:0] rate,
    input logic [SEC_W-1:0]  ld_secs,
    input logic [TICK_W-1:0] ld_ticks,
    input logic [SEC_W-1:0]  now_secs,
    input logic [TICK_W-1:0] now_ticks
);
    // R2
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && now_ticks != rate - TICK_W'(1)) |=>
        (now_ticks == $past(now_ticks) + TICK_W'(1)) && $stable(now_secs));

    // R2
    rollover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && now_ticks == rate - TICK_W'(1)) |=>
        (now_ticks == '0) && (now_secs == $past(now_secs) + SEC_W'(1)));

    // R10
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (now_secs == $past(ld_secs)) && (now_ticks == $past(ld_ticks)));

    // R8
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !arm_wr) |=> !armed);

    // R3
    arm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_wr |=> armed);
endmodule

bind pps_timekeeper tk_checker #(.SEC_W(SEC_W), .TICK_W(TICK_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .commit(commit), .armed(armed), .arm_wr(arm_wr),
    .rate(rate), .ld_secs(ld_secs), .ld_ticks(ld_ticks),
    .now_secs(now_secs), .now_ticks(now_ticks)
);

// File: tb/pps_timekeeper_test.sv
module pps_timekeeper_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEF_TPS    = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_data = '0;
    logic        pps_main = 1'b0;
    logic        pps_aux = 1'b0;
    logic [31:0] now_secs, now_ticks;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    logic [31:0] m_secs, m_ticks, m_rate;
    int          m_base;

    pps_timekeeper #(.DEFAULT_TPS(DEF_TPS)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_data(cfg_data), .pps_main(pps_main), .pps_aux(pps_aux),
        .now_secs(now_secs), .now_ticks(now_ticks)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Expected time n cycles after (s,t) at a rate r, assuming t < r.
    function automatic logic [63:0] advance(logic [31:0] s, logic [31:0] t,
                                            logic [31:0] r, int n);
        logic [63:0] total;
        total = 64'(t) + 64'(n);
        return {s + 32'(total / 64'(r)), 32'(total % 64'(r))};
    endfunction

    task automatic chk(string req, logic [31:0] es, logic [31:0] et);
        checks++;
        if (now_secs !== es || now_ticks !== et) begin
            fails++;
            $display("FAIL %s: got %0d.%0d expected %0d.%0d", req,
                     now_secs, now_ticks, es, et);
        end
    endtask

    task automatic expect_now(string req);
        logic [63:0] e;
        e = advance(m_secs, m_ticks, m_rate, cyc - m_base);
        chk(req, e[63:32], e[31:0]);
    endtask

    task automatic set_base(logic [31:0] s, logic [31:0] t);
        m_secs = s; m_ticks = t; m_base = cyc;
    endtask

    // Called at a negedge; write captured on the next posedge, returns at the negedge after.
    task automatic wr(int idx, logic [31:0] d);
        cfg_we = 1'b1; cfg_idx = idx[2:0]; cfg_data = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic imm_load(logic [31:0] s, logic [31:0] t);
        wr(0, s); wr(1, t); wr(3, 1);
        @(negedge clk);
        chk("R4", s, t);
        set_base(s, t);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1", 32'd0, 32'd0);
        rst_n = 1'b1;
        m_rate = DEF_TPS;

        // R1 default rate, R4 immediate load, R2 rollover
        imm_load(32'd5, 32'd6);
        repeat (3) @(negedge clk);
        chk("R1", 32'd6, 32'd1);

        // R10 load committing in the rollover cycle
        wr(4, 32'd10); m_rate = 10;
        wr(0, 32'd7); wr(1, 32'd9); wr(3, 1);
        wr(3, 1);
        @(negedge clk);
        chk("R10", 32'd7, 32'd9);
        set_base(32'd7, 32'd9);
        repeat (4) @(negedge clk);
        expect_now("R2");

        // R2/R3 random rates, times and waits; unused indices
        for (int i = 0; i < 25; i++) begin
            logic [31:0] r, s, t;
            int n;
            r = 4 + $urandom % 37;
            s = $urandom;
            t = $urandom % r;
            wr(4, r); m_rate = r;
            imm_load(s, t);
            n = $urandom % 60;
            repeat (n) @(negedge clk);
            expect_now("R2");
            if (i % 3 == 0) begin
                wr(5 + ($urandom % 3), $urandom);
                expect_now("R3");
            end
        end

        // PPS tests at a large rate
        wr(4, 32'd1000); m_rate = 1000;
        imm_load(32'd50, 32'd0);

        // R8 edges while unarmed do nothing
        wr(2, 32'd1);
        pps_main = 1'b1; repeat (4) @(negedge clk);
        pps_main = 1'b0; repeat (4) @(negedge clk);
        expect_now("R8");

        // R5/R6 rising edge on the main input
        wr(0, 32'd100); wr(1, 32'd3); wr(3, 0);
        expect_now("R5");
        pps_main = 1'b1;
        repeat (2) @(negedge clk);
        expect_now("R5");
        @(negedge clk);
        chk("R5", 32'd100, 32'd3);
        set_base(32'd100, 32'd3);

        // R8 no reload on a later edge
        pps_main = 1'b0; repeat (4) @(negedge clk);
        pps_main = 1'b1; repeat (4) @(negedge clk);
        expect_now("R8");

        // R6 falling edge selected: a rising edge must not commit
        wr(2, 32'd0);
        pps_main = 1'b0; repeat (4) @(negedge clk);
        wr(0, 32'd200); wr(1, 32'd1); wr(3, 0);
        pps_main = 1'b1; repeat (5) @(negedge clk);
        expect_now("R6");
        pps_main = 1'b0;
        repeat (2) @(negedge clk);
        expect_now("R6");
        @(negedge clk);
        chk("R6", 32'd200, 32'd1);
        set_base(32'd200, 32'd1);

        // R7 auxiliary source, rising; main input ignored
        wr(2, 32'd3);
        wr(0, 32'd300); wr(1, 32'd2); wr(3, 0);
        pps_main = 1'b1; repeat (5) @(negedge clk);
        expect_now("R7");
        pps_main = 1'b0; repeat (5) @(negedge clk);
        expect_now("R7");
        pps_aux = 1'b1;
        repeat (2) @(negedge clk);
        expect_now("R7");
        @(negedge clk);
        chk("R7", 32'd300, 32'd2);
        set_base(32'd300, 32'd2);

        // R9 overwrite after arming, back on main rising
        wr(2, 32'd1);
        repeat (4) @(negedge clk);
        wr(0, 32'd400); wr(1, 32'd5); wr(3, 0);
        wr(0, 32'd444);
        expect_now("R9");
        pps_main = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9", 32'd444, 32'd5);
        set_base(32'd444, 32'd5);
        repeat (20) @(negedge clk);
        expect_now("R2");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule